// File: doc/BRIEF.md
# Variable-Length Instruction Extractor

This block sits between an instruction fetch stage and a set of decoders. It accepts a 16-byte fetch window from a byte stream of variable-length instructions. It hands out up to five whole instructions per cycle on five parallel lanes. A short length pre-decoder sits at every byte position, including three slots for bytes carried over from the previous window. Each one works out the length an instruction would have if it started there. These lengths are registered together with the window bytes. In the following cycle the true instruction starts are found by hopping from the current start position by one decoded length at a time. The raw bytes of the first five complete instructions are then steered onto the lanes.

The length rule is a compact toy encoding: the two least significant bits of an instruction's first byte hold its length minus one, so every instruction is 1 to 4 bytes long. If a window ends partway through an instruction, those trailing bytes are kept. They are joined in front of the next window, so that instruction leaves whole. A window that holds more than five complete instructions is drained over several cycles, and the next window is taken only once the current one has no complete instruction left. A flush input discards everything buffered. The start offset given with the next window then picks where decoding restarts.

Top module: `insn_extract`

## Requirements
- R1: An instruction's length is its first byte's bits [1:0] plus one (1 to 4). Each valid lane gives that length on its 3-bit length field. It carries the instruction's bytes with byte j at lane bits [8j+7:8j], and the bytes beyond the length are zero.
- R2: Lanes fill in program order from lane 0, and the valid lanes always form a contiguous group starting at lane 0. At most five instructions are shown per cycle. Any further complete instructions of the buffered window appear in later cycles. A window of sixteen 1-byte instructions therefore shows 5, 5, 5 and then 1 lanes.
- R3: Instruction starts are found only by stepping from the start position by decoded lengths. Length bits of bytes that are not instruction starts have no effect on the lanes.
- R4: in_ready is low while a buffered window still holds complete instructions that have not been emitted. It rises in the cycle after the last group of complete instructions is taken.
- R5: The first lanes of a window become valid in the cycle that follows the clock edge at which the window was accepted. They are never valid in the cycle in which the window is offered.
- R6: Bytes of an instruction that runs past the end of a window are carried over. The instruction is emitted whole, as the first lane of the next window. Decoding of that window continues straight after it. A window with no complete instruction is released without emitting a lane and without needing out_ready.
- R7: While any lane is valid and out_ready is low, the lanes keep all their values and no instruction is lost.
- R8: in_offset is used only for the first window accepted after reset or flush, where the first instruction starts at that byte of the window. For every later window it is ignored.
- R9: In a cycle with flush high, in_ready is low and no window is taken. In the next cycle no lane is valid and in_ready is high. All buffered instructions and carried bytes are dropped.
- R10: After reset, in_ready is high and no lane is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop all buffered state and restart at the next window |
| in_valid | input | 1 | A fetch window is offered |
| in_ready | output | 1 | The offered window is taken at the next edge |
| in_bytes | input | 128 | Window bytes, byte b at bits [8b+7:8b] |
| in_offset | input | 4 | First instruction's byte position after reset or flush |
| out_ready | input | 1 | Downstream takes all valid lanes at the next edge |
| out_valid | output | 5 | Per-lane valid flags |
| out_len | output | 15 | Per-lane length, 3 bits per lane, zero when the lane is idle |
| out_bytes | output | 160 | Per-lane instruction bytes, 32 bits per lane |

## Verification
If the start position is corrupted, the error appears in the very next emitting cycle. Lane bytes become misaligned, or the length field disagrees with the low bits of the lane's first byte. The bench catches this against its own walk of the byte stream. A lost or stale carry shows up on the first lane after the next window is accepted, so windows that end inside an instruction are driven in several scenarios. A wrong buffer-full state shows up at once as in_ready and the lane pattern going out of step: lanes stay valid while a new window is taken, or windows stall. Per-cycle lane counts and in_ready are therefore compared against the expected drain schedule.

// File: rtl/insn_extract_pkg.sv
package insn_extract_pkg;
   localparam int BYTE_W = 8;

   // Positions decoded per window: window bytes plus carried-over slots.
   function automatic int ext_positions(input int win_bytes, input int max_len);
      return win_bytes + max_len - 1;
   endfunction
endpackage

// File: rtl/ie_len_predecode.sv
module ie_len_predecode import insn_extract_pkg::*; #(
   parameter int POSITIONS = 19,
   parameter int LEN_BITS  = 2,
   parameter int LEN_W     = 3
)(
   input  logic [POSITIONS*BYTE_W-1:0] bytes_i,
   output logic [POSITIONS*LEN_W-1:0]  lens_o
);
   // One speculative length decoder per byte position.
   for (genvar p = 0; p < POSITIONS; p++) begin : g_pos
      assign lens_o[p*LEN_W +: LEN_W] =
         LEN_W'(bytes_i[p*BYTE_W +: LEN_BITS]) + LEN_W'(1);
   end
endmodule

// File: rtl/ie_start_chain.sv
module ie_start_chain #(
   parameter int EXT   = 19,
   parameter int LANES = 5,
   parameter int POS_W = 5,
   parameter int LEN_W = 3
)(
   input  logic [POS_W-1:0]             cursor_i,
   input  logic [EXT*LEN_W-1:0]         lens_i,
   output logic [(LANES+1)*POS_W-1:0]   starts_o,
   output logic [(LANES+1)*LEN_W-1:0]   lane_len_o,
   output logic [LANES:0]               ok_o
);
   logic [POS_W-1:0] s_a [LANES+1];
   logic [LEN_W-1:0] l_a [LANES+1];
   logic             ok_a [LANES+1];

   // Hop from the cursor by each decoded length; a start is usable only
   // when its whole instruction lies inside the buffered bytes.
   always_comb begin
      logic prev;
      logic fit;
      prev = 1'b1;
      s_a[0] = cursor_i;
      for (int k = 0; k <= LANES; k++) begin
         if (s_a[k] < POS_W'(EXT)) l_a[k] = lens_i[int'(s_a[k])*LEN_W +: LEN_W];
         else                      l_a[k] = '0;
         fit = (s_a[k] < POS_W'(EXT)) &&
               ((s_a[k] + POS_W'(l_a[k])) <= POS_W'(EXT));
         ok_a[k] = prev && fit;
         prev = ok_a[k];
         if (k < LANES) s_a[k+1] = ok_a[k] ? s_a[k] + POS_W'(l_a[k]) : s_a[k];
      end
   end

   for (genvar k = 0; k <= LANES; k++) begin : g_out
      assign starts_o[k*POS_W +: POS_W]   = s_a[k];
      assign lane_len_o[k*LEN_W +: LEN_W] = l_a[k];
      assign ok_o[k]                      = ok_a[k];
   end
endmodule

// File: rtl/ie_lane_steer.sv
module ie_lane_steer import insn_extract_pkg::*; #(
   parameter int EXT     = 19,
   parameter int MAX_LEN = 4,
   parameter int POS_W   = 5,
   parameter int LEN_W   = 3
)(
   input  logic [EXT*BYTE_W-1:0]     ext_i,
   input  logic [POS_W-1:0]          start_i,
   input  logic [LEN_W-1:0]          len_i,
   input  logic                      valid_i,
   output logic [MAX_LEN*BYTE_W-1:0] bytes_o
);
   always_comb begin
      for (int j = 0; j < MAX_LEN; j++) begin
         if (valid_i && (j < int'(len_i)) && ((int'(start_i) + j) < EXT))
            bytes_o[j*BYTE_W +: BYTE_W] = ext_i[(int'(start_i) + j)*BYTE_W +: BYTE_W];
         else
            bytes_o[j*BYTE_W +: BYTE_W] = '0;
      end
   end
endmodule

// File: rtl/insn_extract.sv
module insn_extract import insn_extract_pkg::*; #(
   parameter  int WIN_BYTES = 16,
   parameter  int LANES     = 5,
   parameter  int LEN_BITS  = 2,
   localparam int MAX_LEN   = 1 << LEN_BITS,
   localparam int LEN_W     = $clog2(MAX_LEN + 1),
   localparam int OFF_W     = $clog2(WIN_BYTES)
)(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             flush,
   input  logic                             in_valid,
   output logic                             in_ready,
   input  logic [WIN_BYTES*BYTE_W-1:0]      in_bytes,
   input  logic [OFF_W-1:0]                 in_offset,
   input  logic                             out_ready,
   output logic [LANES-1:0]                 out_valid,
   output logic [LANES*LEN_W-1:0]           out_len,
   output logic [LANES*MAX_LEN*BYTE_W-1:0]  out_bytes
);
   localparam int PAD   = MAX_LEN - 1;
   localparam int EXT   = ext_positions(WIN_BYTES, MAX_LEN);
   localparam int POS_W = $clog2(EXT + MAX_LEN + 1);

   if (LEN_BITS < 1 || LEN_BITS > 3) begin : g_bad_len
      $error("insn_extract: LEN_BITS must be 1 to 3");
   end
   if (WIN_BYTES < MAX_LEN) begin : g_bad_win
      $error("insn_extract: window narrower than longest instruction");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("insn_extract: at least one lane needed");
   end

   // Stage 1 state: bytes and pre-decoded lengths of carry slots + window.
   logic [EXT*BYTE_W-1:0] ext_q;
   logic [EXT*LEN_W-1:0]  lens_q;
   logic [POS_W-1:0]      cursor_q;
   logic                  full_q;
   logic                  restart_q;
   logic [LEN_BITS-1:0]   carry_q;
   logic [PAD*BYTE_W-1:0] tail_q;

   logic [EXT*BYTE_W-1:0]           ext_d;
   logic [EXT*LEN_W-1:0]            lens_d;
   logic [(LANES+1)*POS_W-1:0]      starts;
   logic [(LANES+1)*LEN_W-1:0]      lane_len;
   logic [LANES:0]                  ok;
   logic [POS_W-1:0]                next_start;
   logic                            take, emit, release_win;

   assign ext_d = {in_bytes, tail_q};

   ie_len_predecode #(.POSITIONS(EXT), .LEN_BITS(LEN_BITS), .LEN_W(LEN_W)) predec_i (
      .bytes_i (ext_d),
      .lens_o  (lens_d)
   );

   ie_start_chain #(.EXT(EXT), .LANES(LANES), .POS_W(POS_W), .LEN_W(LEN_W)) chain_i (
      .cursor_i   (cursor_q),
      .lens_i     (lens_q),
      .starts_o   (starts),
      .lane_len_o (lane_len),
      .ok_o       (ok)
   );

   assign next_start  = starts[LANES*POS_W +: POS_W];
   assign in_ready    = !full_q && !flush;
   assign take        = in_valid && in_ready;
   assign emit        = full_q && out_ready && ok[0];
   assign release_win = full_q && (!ok[0] || (out_ready && !ok[LANES]));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q    <= 1'b0;
         restart_q <= 1'b1;
         carry_q   <= '0;
         cursor_q  <= '0;
         tail_q    <= '0;
         ext_q     <= '0;
         lens_q    <= '0;
      end else if (flush) begin
         full_q    <= 1'b0;
         restart_q <= 1'b1;
         carry_q   <= '0;
         tail_q    <= '0;
      end else if (full_q) begin
         if (release_win) begin
            full_q  <= 1'b0;
            carry_q <= LEN_BITS'(next_start - POS_W'(WIN_BYTES));
            tail_q  <= ext_q[EXT*BYTE_W-1 -: PAD*BYTE_W];
         end else if (emit) begin
            cursor_q <= next_start;
         end
      end else if (take) begin
         full_q    <= 1'b1;
         restart_q <= 1'b0;
         ext_q     <= ext_d;
         lens_q    <= lens_d;
         cursor_q  <= restart_q ? POS_W'(PAD) + POS_W'(in_offset) : POS_W'(carry_q);
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign out_valid[k] = full_q && ok[k];
      assign out_len[k*LEN_W +: LEN_W] = out_valid[k] ? lane_len[k*LEN_W +: LEN_W] : '0;

      ie_lane_steer #(.EXT(EXT), .MAX_LEN(MAX_LEN), .POS_W(POS_W), .LEN_W(LEN_W)) steer_i (
         .ext_i   (ext_q),
         .start_i (starts[k*POS_W +: POS_W]),
         .len_i   (lane_len[k*LEN_W +: LEN_W]),
         .valid_i (out_valid[k]),
         .bytes_o (out_bytes[k*MAX_LEN*BYTE_W +: MAX_LEN*BYTE_W])
      );
   end
endmodule

// File: rtl/insn_extract_chk.sv
module insn_extract_chk #(
   parameter  int LANES    = 5,
   parameter  int LEN_BITS = 2,
   localparam int MAX_LEN  = 1 << LEN_BITS,
   localparam int LEN_W    = $clog2(MAX_LEN + 1)
)(
   input logic                        clk,
   input logic                        rst_n,
   input logic                        flush,
   input logic                        in_ready,
   input logic                        out_ready,
   input logic [LANES-1:0]            out_valid,
   input logic [LANES*LEN_W-1:0]      out_len,
   input logic [LANES*MAX_LEN*8-1:0]  out_bytes
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      // R1
      len_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[k] |-> out_len[k*LEN_W +: LEN_W] ==
            LEN_W'(out_bytes[k*MAX_LEN*8 +: LEN_BITS]) + LEN_W'(1));
      if (k > 0) begin : g_pref
         // R2
         lane_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[k] |-> out_valid[k-1]);
      end
   end

   // R4
   hold_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|out_valid) |-> !in_ready);

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|out_valid) && !out_ready && !flush) |=>
         ($stable(out_valid) && $stable(out_len) && $stable(out_bytes)));

   // R9
   flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !in_ready);

   // R9
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (out_valid == '0));
endmodule

bind insn_extract insn_extract_chk #(.LANES(LANES), .LEN_BITS(LEN_BITS)) chk_i (.*);

// File: tb/insn_extract_tb_top.sv
module insn_extract_tb_top;
   localparam int WIN   = 16;
   localparam int LANES = 5;
   localparam int LW    = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic                 rst_n, flush, in_valid, in_ready, out_ready;
   logic [WIN*8-1:0]     in_bytes;
   logic [3:0]           in_offset;
   logic [LANES-1:0]     out_valid;
   logic [LANES*LW-1:0]  out_len;
   logic [LANES*32-1:0]  out_bytes;

   insn_extract dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
      .in_ready(in_ready), .in_bytes(in_bytes), .in_offset(in_offset),
      .out_ready(out_ready), .out_valid(out_valid), .out_len(out_len),
      .out_bytes(out_bytes)
   );

   int checks = 0;
   int errors = 0;

   logic [7:0] stream [0:1023];
   int  win_limit, win_fed, exp_pos, emitted, offset, rmode, cyc, hcnt;
   bit  first_win, prev_stall;
   int  nv_hist  [0:63];
   bit  acc_hist [0:63];
   bit  rdy_hist [0:63];
   logic [LANES-1:0]    pv;
   logic [LANES*LW-1:0] pl;
   logic [LANES*32-1:0] pb;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Heads follow the 2-bit length rule; body and filler bytes are arbitrary.
   task automatic gen_stream(input int kind, input int off, input int nbytes);
      int p, l;
      for (int i = 0; i < 1024; i++) stream[i] = 8'(i * 29 + kind);
      p = off;
      while (p < nbytes) begin
         case (kind)
            0:       l = 1;
            1:       l = ((p * 13 + 7) / 3) % 4 + 1;
            2:       l = 4;
            default: l = (p * 5 + p / 7) % 4 + 1;
         endcase
         stream[p] = {6'(p * 5 + kind), 2'(l - 1)};
         for (int j = 1; j < l; j++) stream[p + j] = 8'(p * 37 + j * 11 + kind * 3);
         p += l;
      end
   endtask

   function automatic int end_pos();
      int pos = offset;
      while (pos + int'(stream[pos][1:0]) + 1 <= win_limit * WIN)
         pos += int'(stream[pos][1:0]) + 1;
      return pos;
   endfunction

   task automatic step();
      int  nv;
      bit  acc;
      @(negedge clk);
      in_valid = (win_fed < win_limit);
      for (int b = 0; b < WIN; b++) in_bytes[b*8 +: 8] = stream[win_fed * WIN + b];
      in_offset = first_win ? 4'(offset) : 4'(cyc * 7 + 3); // R8: junk later
      case (rmode)
         1:       out_ready = (cyc % 3) != 1;
         2:       out_ready = (win_fed >= 2);
         default: out_ready = 1'b1;
      endcase
      flush = 1'b0;
      #2;
      if (prev_stall)
         chk(out_valid == pv && out_len == pl && out_bytes == pb, "R7",
             "lanes changed under backpressure", 64'(out_bytes ^ pb), 64'd0);
      nv = $countones(out_valid);
      chk(out_valid == LANES'((1 << nv) - 1), "R2", "lanes not a prefix",
          64'(out_valid), 64'((1 << nv) - 1));
      if (out_ready) begin
         for (int k = 0; k < nv; k++) begin
            int el;
            logic [31:0] eb;
            el = int'(stream[exp_pos][1:0]) + 1;
            for (int j = 0; j < 4; j++) eb[j*8 +: 8] = (j < el) ? stream[exp_pos + j] : 8'h00;
            chk(out_len[k*LW +: LW] == LW'(el) && out_bytes[k*32 +: 32] == eb, "R1",
                "lane length and bytes", {29'd0, out_len[k*LW +: LW], out_bytes[k*32 +: 32]},
                {29'd0, LW'(el), eb});
            exp_pos += el;
            emitted++;
         end
      end
      prev_stall = (nv > 0) && !out_ready;
      pv = out_valid; pl = out_len; pb = out_bytes;
      acc = in_valid && in_ready;
      if (hcnt < 64) begin
         nv_hist[hcnt] = nv; acc_hist[hcnt] = acc; rdy_hist[hcnt] = in_ready;
         hcnt++;
      end
      if (acc) begin
         win_fed++;
         first_win = 1'b0;
      end
      cyc++;
   endtask

   task automatic drain(input string req);
      int idle = 0;
      int guard = 0;
      while ((win_fed < win_limit || idle < 4) && guard < 2000) begin
         step();
         idle = (win_fed >= win_limit && out_valid == '0) ? idle + 1 : 0;
         guard++;
      end
      chk(exp_pos == end_pos(), req, "stream end position", 64'(exp_pos), 64'(end_pos()));
   endtask

   task automatic do_flush(input int off);
      @(negedge clk);
      flush = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
      #2;
      chk(in_ready == 1'b0, "R9", "in_ready during flush", 64'(in_ready), 64'd0);
      @(negedge clk);
      flush = 1'b0;
      #2;
      chk(out_valid == '0, "R9", "lanes after flush", 64'(out_valid), 64'd0);
      chk(in_ready == 1'b1, "R9", "in_ready after flush", 64'(in_ready), 64'd1);
      prev_stall = 1'b0;
      win_fed = 0; first_win = 1'b1; offset = off; exp_pos = off;
      hcnt = 0; cyc = 0; emitted = 0;
   endtask

   task automatic run(input int kind, input int off, input int nwin,
                      input int mode, input string req);
      do_flush(off);
      gen_stream(kind, off, nwin * WIN);
      win_limit = nwin;
      rmode = mode;
      drain(req);
   endtask

   task automatic t_reset();
      @(negedge clk);
      #2;
      chk(in_ready == 1'b1, "R10", "in_ready after reset", 64'(in_ready), 64'd1);
      chk(out_valid == '0, "R10", "lanes after reset", 64'(out_valid), 64'd0);
   endtask

   task automatic t_burst();
      int a = -1;
      do_flush(0);
      gen_stream(0, 0, WIN);
      win_limit = 1; rmode = 0;
      for (int i = 0; i < 10; i++) step();
      for (int i = 9; i >= 0; i--) if (acc_hist[i]) a = i;
      chk(a >= 0 && a < 4, "R5", "window accepted", 64'(a), 64'd0);
      if (a >= 0 && a < 4) begin
         chk(nv_hist[a] == 0, "R5", "lanes in accept cycle", 64'(nv_hist[a]), 64'd0);
         chk(nv_hist[a+1] == 5, "R5", "lanes one cycle later", 64'(nv_hist[a+1]), 64'd5);
         chk(nv_hist[a+2] == 5, "R2", "second group", 64'(nv_hist[a+2]), 64'd5);
         chk(nv_hist[a+3] == 5, "R2", "third group", 64'(nv_hist[a+3]), 64'd5);
         chk(nv_hist[a+4] == 1, "R2", "last group", 64'(nv_hist[a+4]), 64'd1);
         for (int i = 1; i <= 4; i++)
            chk(rdy_hist[a+i] == 1'b0, "R4", "in_ready while draining", 64'(rdy_hist[a+i]), 64'd0);
         chk(rdy_hist[a+5] == 1'b1, "R4", "in_ready after drain", 64'(rdy_hist[a+5]), 64'd1);
      end
      chk(exp_pos == WIN, "R2", "instructions emitted", 64'(exp_pos), 64'(WIN));
   endtask

   // R3 R6 R8: mixed lengths crossing window edges, junk offsets later.
   task automatic t_mixed();
      run(1, 6, 8, 0, "R3");
   endtask

   task automatic t_wide();
      run(2, 2, 6, 0, "R6");
   endtask

   task automatic t_stall();
      run(3, 9, 6, 1, "R7");
   endtask

   task automatic t_partial();
      int n = 0;
      do_flush(15);
      gen_stream(2, 15, 2 * WIN);
      win_limit = 2; rmode = 2;
      while (win_fed < 2 && n < 8) begin
         step();
         chk(out_valid == '0, "R6", "no lane for empty window", 64'(out_valid), 64'd0);
         n++;
      end
      chk(win_fed == 2, "R6", "empty window released", 64'(win_fed), 64'd2);
      drain("R6");
      chk(emitted >= 1, "R6", "carried instruction emitted", 64'(emitted), 64'd1);
   endtask

   task automatic t_flush();
      do_flush(0);
      gen_stream(1, 0, 4 * WIN);
      win_limit = 4; rmode = 0;
      for (int i = 0; i < 6; i++) step();
      do_flush(5);
      gen_stream(3, 5, 3 * WIN);
      win_limit = 3; rmode = 0;
      drain("R9");
   endtask

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
      in_bytes = '0; in_offset = '0;
      win_limit = 0; win_fed = 0; exp_pos = 0; emitted = 0; offset = 0;
      rmode = 0; cyc = 0; hcnt = 0; first_win = 1'b1; prev_stall = 1'b0;
      pv = '0; pl = '0; pb = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_burst();
      t_mixed();
      t_wide();
      t_stall();
      t_partial();
      t_flush();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule